// File: doc/BRIEF.md
# Iteration-Trial Concatenated Decode Controller

This controller runs the outer-code retries for one sector. The sector is one outer codeword cut into equal segments. Each segment carries its own inner code. For every segment the inner decoder leaves a pass/fail flag and the hard decisions it held after each of its iterations. When every segment passes, the sector needs no outer correction and the controller reports success at once. When segments fail, the controller treats the error count across inner iterations as something that can rise and fall. It does not trust only the final iteration. It walks every combination of iteration choices across the failed segments. For each combination it sets the read indices of the hard-decision store and launches the external outer decoder. It stops at the first combination that decodes, or after the last one.

The default configuration has 8 segments, 8 inner iterations per segment and at most 3 failed segments enumerated. Before it enumerates, the controller scans the fail flags from segment 0 upward, one segment per clock, and builds the list of failed segments. The FSM states are `ST_IDLE` (waiting for a sector), `ST_SCAN` (listing failed segments), `ST_LAUNCH` (one-cycle outer start), `ST_WAIT` (waiting for the outer verdict) and `ST_FINISH` (one-cycle sector report).

The transitions are:
- `ST_IDLE`→`ST_SCAN` on `sector_start`.
- `ST_SCAN`→`ST_FINISH` when the scan ends with no failures or with too many.
- `ST_SCAN`→`ST_LAUNCH` otherwise.
- `ST_LAUNCH`→`ST_WAIT` always.
- `ST_WAIT`→`ST_FINISH` on an accepting verdict or after the final combination.
- `ST_WAIT`→`ST_LAUNCH` on a rejecting verdict while combinations remain, and the choice advances.
- `ST_FINISH`→`ST_IDLE` always.

Top module: `trial_decode_ctrl`

## Requirements
- R1: After reset `busy`, `outer_start`, `sector_done` and `sector_ok` are 0 and `attempts` is 0.
- R2: A `sector_start` pulse while idle captures `seg_fail` (bit s set means segment s failed) and raises `busy` until the cycle after `sector_done`. Failed segments are listed in ascending segment number.
- R3: If no segment failed, `sector_done` pulses with `sector_ok`=1 and `attempts`=0, and `outer_start` never pulses.
- R4: If more than MAX_FAIL segments failed, `sector_done` pulses with `sector_ok`=0 and `attempts`=0, and `outer_start` never pulses.
- R5: During an attempt, every segment that did not fail drives index code ITER_MAX-1 (its final iteration) on its `sel_iter` field, at bits [s*3 +: 3] by default. Each failed segment drives the code of its chosen iteration, where code k means iteration k+1.
- R6: `outer_start` is a one-cycle pulse, one per attempt. `sel_iter` stays unchanged from that pulse until the verdict arrives on `outer_done`.
- R7: The first attempt uses code 0 for every failed segment. The choice for the highest-numbered failed segment changes fastest and carries into the next lower one, like an odometer.
- R8: The first attempt whose `outer_done` comes with `outer_ok`=1 ends the sector with `sector_ok`=1. `attempts` then equals the number of `outer_start` pulses so far.
- R9: If all ITER_MAX^n combinations are rejected, with n the number of failed segments, the sector ends with `sector_ok`=0 and `attempts`=ITER_MAX^n.
- R10: `sector_done` is a one-cycle pulse. A `sector_start` that arrives while busy is ignored and does not change the outcome or `attempts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sector_start | input | 1 | Begin a sector; `seg_fail` is sampled in the same cycle |
| seg_fail | input | NUM_SEG | Per-segment inner decode failure flags |
| sel_iter | output | NUM_SEG*clog2(ITER_MAX) | Per-segment iteration index into the hard-decision store |
| outer_start | output | 1 | Launch one outer decode on the current selection |
| outer_done | input | 1 | Outer decoder verdict valid |
| outer_ok | input | 1 | Outer decode succeeded (qualified by `outer_done`) |
| sector_done | output | 1 | Sector outcome valid for one cycle |
| sector_ok | output | 1 | Sector decoded |
| attempts | output | clog2(ITER_MAX)*MAX_FAIL+1 | Outer decode attempts made for this sector |
| busy | output | 1 | A sector is in progress |

## Verification
The hardest state to reach is the end of a full three-segment sweep. There the odometer must roll over through every digit, 512 times, and the exhaustion decision must come on exactly the last combination. The bench gets there with an outer-decoder model that rejects every attempt. After each launch the model checks the whole selection vector against an enumeration the bench keeps itself. Nearby cases are also covered: a success on the very last iteration of a single failure, a two-failure hit in the middle of the sweep, a rejected sector with one more failure than the bound, and a stray `sector_start` sent while a verdict is outstanding.

// File: rtl/trial_pkg.sv
package trial_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } trial_state_t;
endpackage

// File: rtl/trial_fail_scan.sv
module trial_fail_scan #(
    parameter int NUM_SEG  = 8,
    parameter int MAX_FAIL = 3,
    localparam int SW = $clog2(NUM_SEG),
    localparam int FW = $clog2(MAX_FAIL + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [NUM_SEG-1:0]             flags,
    output logic [MAX_FAIL-1:0][SW-1:0]    fail_list,
    output logic [FW-1:0]                  nfail,
    output logic                           overflow,
    output logic                           scan_done
);
    logic [NUM_SEG-1:0] flags_q;
    logic [SW-1:0]      idx_q;
    logic               run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q   <= '0;
            idx_q     <= '0;
            run_q     <= 1'b0;
            nfail     <= '0;
            overflow  <= 1'b0;
            scan_done <= 1'b0;
            fail_list <= '0;
        end else begin
            scan_done <= 1'b0;
            if (load) begin
                flags_q  <= flags;
                idx_q    <= '0;
                run_q    <= 1'b1;
                nfail    <= '0;
                overflow <= 1'b0;
            end else if (run_q) begin
                if (flags_q[idx_q]) begin
                    if (nfail == FW'(MAX_FAIL)) begin
                        overflow <= 1'b1;
                    end else begin
                        fail_list[nfail] <= idx_q;
                        nfail            <= nfail + 1'b1;
                    end
                end
                if (idx_q == SW'(NUM_SEG - 1)) begin
                    run_q     <= 1'b0;
                    scan_done <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/trial_odometer.sv
module trial_odometer #(
    parameter int ITER_MAX = 8,
    parameter int MAX_FAIL = 3,
    localparam int IW = $clog2(ITER_MAX),
    localparam int FW = $clog2(MAX_FAIL + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           step,
    input  logic [FW-1:0]                  nfail,
    output logic [MAX_FAIL-1:0][IW-1:0]    digits,
    output logic                           last
);
    localparam logic [IW-1:0] TOP = IW'(ITER_MAX - 1);

    logic [MAX_FAIL-1:0][IW-1:0] next_digits;

    always_comb begin
        logic carry;
        carry       = 1'b1;
        last        = 1'b1;
        next_digits = digits;
        for (int i = MAX_FAIL - 1; i >= 0; i--) begin
            if (i < int'(nfail)) begin
                if (digits[i] != TOP) last = 1'b0;
                if (carry) begin
                    if (digits[i] == TOP) begin
                        next_digits[i] = '0;
                    end else begin
                        next_digits[i] = digits[i] + 1'b1;
                        carry          = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     digits <= '0;
        else if (clear) digits <= '0;
        else if (step)  digits <= next_digits;
    end
endmodule

// File: rtl/trial_sel_map.sv
module trial_sel_map #(
    parameter int NUM_SEG  = 8,
    parameter int ITER_MAX = 8,
    parameter int MAX_FAIL = 3,
    localparam int IW = $clog2(ITER_MAX),
    localparam int SW = $clog2(NUM_SEG),
    localparam int FW = $clog2(MAX_FAIL + 1)
) (
    input  logic [MAX_FAIL-1:0][SW-1:0]    fail_list,
    input  logic [FW-1:0]                  nfail,
    input  logic [MAX_FAIL-1:0][IW-1:0]    digits,
    output logic [NUM_SEG*IW-1:0]          sel_iter
);
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        always_comb begin
            sel_iter[s*IW +: IW] = IW'(ITER_MAX - 1);
            for (int k = 0; k < MAX_FAIL; k++) begin
                if (k < int'(nfail) && fail_list[k] == SW'(s))
                    sel_iter[s*IW +: IW] = digits[k];
            end
        end
    end
endmodule

// File: rtl/trial_decode_ctrl.sv
module trial_decode_ctrl
    import trial_pkg::*;
#(
    parameter int NUM_SEG  = 8,
    parameter int ITER_MAX = 8,
    parameter int MAX_FAIL = 3
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        sector_start,
    input  logic [NUM_SEG-1:0]                          seg_fail,
    output logic [NUM_SEG*$clog2(ITER_MAX)-1:0]         sel_iter,
    output logic                                        outer_start,
    input  logic                                        outer_done,
    input  logic                                        outer_ok,
    output logic                                        sector_done,
    output logic                                        sector_ok,
    output logic [$clog2(ITER_MAX)*MAX_FAIL:0]          attempts,
    output logic                                        busy
);
    localparam int IW = $clog2(ITER_MAX);
    localparam int SW = $clog2(NUM_SEG);
    localparam int FW = $clog2(MAX_FAIL + 1);
    localparam int AW = IW * MAX_FAIL + 1;

    trial_state_t state_q, state_d;

    logic [MAX_FAIL-1:0][SW-1:0] fail_list;
    logic [MAX_FAIL-1:0][IW-1:0] digits;
    logic [FW-1:0]               nfail;
    logic                        overflow, scan_done, last;
    logic                        scan_load, odo_step;

    trial_fail_scan #(.NUM_SEG(NUM_SEG), .MAX_FAIL(MAX_FAIL)) u_scan (
        .clk(clk), .rst_n(rst_n), .load(scan_load), .flags(seg_fail),
        .fail_list(fail_list), .nfail(nfail), .overflow(overflow),
        .scan_done(scan_done)
    );

    trial_odometer #(.ITER_MAX(ITER_MAX), .MAX_FAIL(MAX_FAIL)) u_odo (
        .clk(clk), .rst_n(rst_n), .clear(scan_load), .step(odo_step),
        .nfail(nfail), .digits(digits), .last(last)
    );

    trial_sel_map #(.NUM_SEG(NUM_SEG), .ITER_MAX(ITER_MAX), .MAX_FAIL(MAX_FAIL)) u_map (
        .fail_list(fail_list), .nfail(nfail), .digits(digits), .sel_iter(sel_iter)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sector_start) state_d = ST_SCAN;
            ST_SCAN:   if (scan_done)
                           state_d = (overflow || nfail == '0) ? ST_FINISH : ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (outer_done)
                           state_d = (outer_ok || last) ? ST_FINISH : ST_LAUNCH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        scan_load   = (state_q == ST_IDLE) && sector_start;
        odo_step    = (state_q == ST_WAIT) && outer_done && !outer_ok && !last;
        outer_start = (state_q == ST_LAUNCH);
        sector_done = (state_q == ST_FINISH);
        busy        = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sector_ok <= 1'b0;
            attempts  <= '0;
        end else if (scan_load) begin
            sector_ok <= 1'b0;
            attempts  <= '0;
        end else begin
            if (state_q == ST_SCAN && scan_done && !overflow && nfail == '0)
                sector_ok <= 1'b1;
            if (state_q == ST_WAIT && outer_done && outer_ok)
                sector_ok <= 1'b1;
            if (state_q == ST_LAUNCH)
                attempts <= attempts + AW'(1);
        end
    end
endmodule

// File: rtl/trial_decode_chk.sv
module trial_decode_chk #(
    parameter int NUM_SEG  = 8,
    parameter int ITER_MAX = 8,
    parameter int MAX_FAIL = 3
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_SEG*$clog2(ITER_MAX)-1:0] sel_iter,
    input logic                                outer_start,
    input logic                                outer_done,
    input logic                                outer_ok,
    input logic                                sector_done,
    input logic                                sector_ok,
    input logic [$clog2(ITER_MAX)*MAX_FAIL:0]  attempts,
    input logic                                busy
);
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        outer_start |=> !outer_start);

    p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        outer_start |=> $stable(sel_iter));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sector_done |=> !sector_done);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!outer_start && !sector_done));

    p_end_after_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && attempts != '0) |-> $past(outer_done));

    p_ok_follows_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && attempts != '0) |-> (sector_ok == $past(outer_ok)));
endmodule

bind trial_decode_ctrl trial_decode_chk #(
    .NUM_SEG(NUM_SEG), .ITER_MAX(ITER_MAX), .MAX_FAIL(MAX_FAIL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_iter(sel_iter), .outer_start(outer_start),
    .outer_done(outer_done), .outer_ok(outer_ok), .sector_done(sector_done),
    .sector_ok(sector_ok), .attempts(attempts), .busy(busy)
);

// File: tb/test_trial_decode_ctrl.sv
module test_trial_decode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG = 8;
    localparam int NIT  = 8;
    localparam int NMAX = 3;
    localparam int IW   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sector_start = 1'b0;
    logic [NSEG-1:0]   seg_fail = '0;
    logic [NSEG*IW-1:0] sel_iter;
    logic              outer_start;
    logic              outer_done = 1'b0;
    logic              outer_ok = 1'b0;
    logic              sector_done;
    logic              sector_ok;
    logic [IW*NMAX:0]  attempts;
    logic              busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trial_decode_ctrl #(.NUM_SEG(NSEG), .ITER_MAX(NIT), .MAX_FAIL(NMAX)) i_trial_decode_ctrl (
        .clk(clk), .rst_n(rst_n), .sector_start(sector_start), .seg_fail(seg_fail),
        .sel_iter(sel_iter), .outer_start(outer_start), .outer_done(outer_done),
        .outer_ok(outer_ok), .sector_done(sector_done), .sector_ok(sector_ok),
        .attempts(attempts), .busy(busy)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One sector: fails = failed segment flags; target codes t0..t2 accepted if has_tgt.
    task automatic run_case(input string req, input logic [NSEG-1:0] fails,
                            input bit has_tgt, input int t0, input int t1, input int t2,
                            input bit poke);
        int fl[NSEG];
        int e[NMAX];
        int tg[NMAX];
        int n = 0;
        int starts = 0;
        int sel_err = 0;
        int other_err = 0;
        int exp_att;
        bit exp_ok;
        bit fin = 0;
        bit got_ok = 0;
        int got_att = 0;
        int cyc = 0;
        tg[0] = t0; tg[1] = t1; tg[2] = t2;
        for (int s = 0; s < NSEG; s++) if (fails[s]) begin fl[n] = s; n++; end
        for (int k = 0; k < NMAX; k++) e[k] = 0;
        if (n == 0) begin exp_att = 0; exp_ok = 1; end
        else if (n > NMAX) begin exp_att = 0; exp_ok = 0; end
        else if (has_tgt) begin
            exp_att = 0;
            for (int k = 0; k < n; k++) exp_att = exp_att * NIT + tg[k];
            exp_att = exp_att + 1; exp_ok = 1;
        end else begin
            exp_att = 1;
            for (int k = 0; k < n; k++) exp_att = exp_att * NIT;
            exp_ok = 0;
        end

        @(negedge clk); seg_fail = fails; sector_start = 1'b1;
        @(negedge clk); sector_start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        while (!fin && cyc < 10000) begin
            if (sector_done) begin
                fin = 1; got_ok = sector_ok; got_att = int'(attempts);
            end else if (outer_start) begin
                bit match = 1;
                starts++;
                for (int s = 0; s < NSEG; s++) begin
                    int pos = -1;
                    for (int k = 0; k < n; k++) if (fl[k] == s) pos = k;
                    if (pos < 0) begin
                        if (int'(sel_iter[s*IW +: IW]) != NIT - 1) other_err++;
                    end else begin
                        if (int'(sel_iter[s*IW +: IW]) != e[pos]) sel_err++;
                        if (!has_tgt || e[pos] != tg[pos]) match = 0;
                    end
                end
                for (int k = n - 1; k >= 0; k--) begin
                    if (e[k] == NIT - 1) e[k] = 0;
                    else begin e[k]++; break; end
                end
                @(negedge clk);
                outer_done = 1'b1; outer_ok = match;
                if (poke && starts == 1) begin sector_start = 1'b1; seg_fail = '0; end
                @(negedge clk);
                outer_done = 1'b0; outer_ok = 1'b0; sector_start = 1'b0;
                cyc += 2;
                continue;
            end
            @(negedge clk); cyc++;
        end
        chk(fin, req, "sector_done reached", int'(fin), 1);
        chk(got_ok == exp_ok, req, "sector_ok", int'(got_ok), int'(exp_ok));
        chk(got_att == exp_att, req, "attempts", got_att, exp_att);
        chk(starts == exp_att, req, "outer_start pulses", starts, exp_att);
        chk(sel_err == 0, "R7", "failed-segment selection mismatches", sel_err, 0);
        chk(other_err == 0, "R5", "passing-segment selection mismatches", other_err, 0);
        @(negedge clk);
        chk(!sector_done && !busy, "R10", "done pulse over and idle", int'(sector_done), 0);
    endtask

    task automatic test_reset();
        // R1
        chk(!busy && !outer_start && !sector_done, "R1", "control outputs after reset",
            int'({busy, outer_start, sector_done}), 0);
        chk(!sector_ok && attempts == '0, "R1", "result after reset", int'(attempts), 0);
    endtask

    task automatic test_clean();      run_case("R3", 8'b0000_0000, 0, 0, 0, 0, 0); endtask
    task automatic test_single_poke(); run_case("R8", 8'b0010_0000, 1, 3, 0, 0, 1); endtask  // R10 poke
    task automatic test_last_iter();   run_case("R8", 8'b0000_0001, 1, 7, 0, 0, 0); endtask
    task automatic test_pair();        run_case("R7", 8'b0100_0010, 1, 2, 5, 0, 0); endtask
    task automatic test_exhaust_one(); run_case("R9", 8'b1000_0000, 0, 0, 0, 0, 0); endtask
    task automatic test_exhaust_three(); run_case("R9", 8'b1000_1001, 0, 0, 0, 0, 0); endtask
    task automatic test_overflow();    run_case("R4", 8'b0101_0101, 0, 0, 0, 0, 0); endtask

    initial begin
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 200000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_clean();
        test_single_poke();
        test_last_iter();
        test_pair();
        test_exhaust_one();
        test_exhaust_three();
        test_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule